// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single timer/counter channel on a small register bus. Software sets a terminal value, optionally presets the count, and selects a clock divisor and a run mode. It then sets the run bit. The counter advances once per divided clock. When it is at the terminal value on a divided tick, a sticky event flag is raised. The channel then either restarts from zero (periodic mode) or clears its own run bit and halts (single-shot mode).

The event flag drives one level interrupt line through an enable bit. Software clears the flag by writing a one to its bit. The bus has no read strobe. The read data always reflects the register that the address selects, and the count register shows the live counter value.

Top module: `pit_channel`

## Requirements
- R1: After synchronous reset, all four registers read zero and `irq_o` is low.
- R2: Address bits [3:2] select the register: 0 = terminal value (bits 27:0), 1 = count (bits 27:0), 2 = control (bit 28 run, bit 24 mode, bits 15:0 divisor), 3 = interrupt (bit 20 enable, bit 16 flag). All other bits read zero.
- R3: While running with divisor D >= 2, the count advances once every D clock cycles. The first advance comes D cycles after the control write that set the run bit, because the divider restarts whenever the channel is stopped.
- R4: A divisor field of 0 or 1 behaves exactly like 2.
- R5: A divided tick taken while the count equals the terminal value N sets the flag. From a start at zero, this happens (N+1)*D cycles after the run bit is set.
- R6: In periodic mode (bit 24 = 1), the tick that matches the terminal value returns the count to zero, and counting continues.
- R7: In single-shot mode (bit 24 = 0), the tick that matches the terminal value clears the run bit, and the count stays at N.
- R8: Writing 1 to bit 16 of the interrupt register clears the flag, and writing 0 there leaves it unchanged. If a match and a clearing write fall in the same cycle, the flag stays set.
- R9: `irq_o` is high exactly when the flag and the interrupt enable are both set.
- R10: A write to the count register loads bits 27:0 into the counter, so writing zero resets it. Writing zero to control stops the channel, and the count then holds.
- R11: A read of the count register returns the current counter value while the channel runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset within the channel window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_rdata | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong divider phase or a wrong counter step shows up at once in the count readback, because every read gives floor(cycles/D), taken modulo N+1 in periodic mode. A wrong match or wrap shows up at the first terminal tick. It appears as a misplaced `irq_o` edge, a count that does not return to zero, or a run bit that is still set. A lost or wrongly cleared flag appears on `irq_o` in the cycle after the clearing write or the match.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BUS_W        = 32;
    localparam int RUN_BIT      = 28;
    localparam int MODE_BIT     = 24;
    localparam int FLAG_BIT     = 16;
    localparam int IEN_BIT      = 20;
    localparam int MIN_DIV      = 2;

    typedef enum logic [1:0] {
        SEL_TERM  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_IRQ   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_SINGLE   = 1'b0,
        MODE_PERIODIC = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic      run;
        run_mode_e mode;
    } ctrl_flags_t;

    typedef struct packed {
        logic             we;
        reg_sel_e         sel;
        logic [BUS_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic hit;
        logic stop;
    } cnt_event_t;

    function automatic logic [31:0] clamp_div(input logic [31:0] raw);
        return (raw < MIN_DIV) ? 32'(MIN_DIV) : raw;
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
    import pit_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last_phase;

    always_comb begin
        last_phase = DIV_W'(clamp_div(32'(div)) - 32'd1);
    end

    assign tick = run && (phase_q >= last_phase);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_idle_no_tick_R10: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  ctrl_flags_t      flags,
    input  logic [CNT_W-1:0] term,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output cnt_event_t       evt
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_term;

    assign at_term  = (cnt_q == term);
    assign evt.hit  = tick && at_term;
    assign evt.stop = tick && at_term && (flags.mode == MODE_SINGLE);
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            if (at_term) begin
                if (flags.mode == MODE_PERIODIC) begin
                    cnt_q <= '0;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!flags.run && !load) |=> $stable(cnt_q));

    assert_periodic_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.hit && flags.mode == MODE_PERIODIC && !load) |=> (cnt_q == '0));

    assert_single_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && !load) |=> $stable(cnt_q));

    assert_load_value_R10: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int CNT_W  = 28,
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  count,
    input  cnt_event_t        evt,
    output ctrl_flags_t       flags,
    output logic [DIV_W-1:0]  div,
    output logic [CNT_W-1:0]  term,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);

    bus_req_t         req;
    ctrl_flags_t      flags_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] term_q;
    logic             ien_q;
    logic             flag_q;
    logic             wr_term, wr_ctrl, wr_irq, flag_clr;

    always_comb begin
        req.we   = bus_we;
        req.sel  = reg_sel_e'(bus_addr[3:2]);
        req.data = bus_wdata;
    end

    assign wr_term  = req.we && (req.sel == SEL_TERM);
    assign load     = req.we && (req.sel == SEL_COUNT);
    assign wr_ctrl  = req.we && (req.sel == SEL_CTRL);
    assign wr_irq   = req.we && (req.sel == SEL_IRQ);
    assign flag_clr = wr_irq && req.data[FLAG_BIT];
    assign load_val = req.data[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            term_q <= '0;
        end else if (wr_term) begin
            term_q <= req.data[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '{run: 1'b0, mode: MODE_SINGLE};
            div_q   <= '0;
        end else if (wr_ctrl) begin
            flags_q.run  <= req.data[RUN_BIT];
            flags_q.mode <= run_mode_e'(req.data[MODE_BIT]);
            div_q        <= req.data[DIV_W-1:0];
        end else if (evt.stop) begin
            flags_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_irq) begin
                ien_q <= req.data[IEN_BIT];
            end
            if (evt.hit) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (req.sel)
            SEL_TERM:  rdata[CNT_W-1:0] = term_q;
            SEL_COUNT: rdata[CNT_W-1:0] = count;
            SEL_CTRL: begin
                rdata[RUN_BIT]     = flags_q.run;
                rdata[MODE_BIT]    = flags_q.mode;
                rdata[DIV_W-1:0]   = div_q;
            end
            SEL_IRQ: begin
                rdata[IEN_BIT]  = ien_q;
                rdata[FLAG_BIT] = flag_q;
            end
            default: rdata = '0;
        endcase
    end

    assign flags = flags_q;
    assign div   = div_q;
    assign term  = term_q;
    assign irq   = flag_q & ien_q;

    assert_hit_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> flag_q);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q);

    assert_clear_drops_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !evt.hit) |=> !flag_q);

    assert_stop_clears_run_R7: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && !wr_ctrl) |=> !flags_q.run);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W  = 28,
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);

    ctrl_flags_t      flags;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] term;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             tick;
    cnt_event_t       evt;

    pit_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .count    (count),
        .evt      (evt),
        .flags    (flags),
        .div      (div),
        .term     (term),
        .load     (load),
        .load_val (load_val),
        .rdata    (bus_rdata),
        .irq      (irq_o)
    );

    pit_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk (clk),
        .rst (rst),
        .run (flags.run),
        .div (div),
        .tick(tick)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .flags   (flags),
        .term    (term),
        .load    (load),
        .load_val(load_val),
        .count   (count),
        .evt     (evt)
    );

    assert_irq_needs_event_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(evt.hit) || $past(bus_we)));

endmodule

// File: tb/pit_channel_tb_top.sv
module pit_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [3:0] A_TERM = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_IRQ = 4'hC;
    localparam logic [31:0] RUN = 32'h1000_0000, PER = 32'h0100_0000;
    localparam logic [31:0] IEN = 32'h0010_0000, FLG = 32'h0001_0000;

    always #5 clk = ~clk;

    pit_channel dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic int eff(input int d);
        return (d < 2) ? 2 : d;
    endfunction

    function automatic int exp_count(input int m, input int d, input int n, input bit per);
        int t = m / eff(d);
        if (per) return t % (n + 1);
        return (t > n) ? n : t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic arm(input int n, input int d, input bit per);
        wr(A_CTRL, 32'h0);
        wr(A_IRQ, IEN | FLG);
        wr(A_CNT, 32'h0);
        wr(A_TERM, 32'(n));
        wr(A_CTRL, RUN | (per ? PER : 32'h0) | 32'(d));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_TERM, v); check("R1 term", v, 0);
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_IRQ, v);  check("R1 irq reg", v, 0);
        check("R1 irq_o", {31'b0, irq_o}, 0);

        // R2 field layout and unused bits
        wr(A_TERM, 32'hFFFF_FFFF); rd(A_TERM, v); check("R2 term bits", v, 32'h0FFF_FFFF);
        wr(A_CTRL, 32'hEFFF_FFFF); rd(A_CTRL, v); check("R2 ctrl bits", v, 32'h0100_FFFF);
        wr(A_CTRL, 32'h0);
        wr(A_IRQ, 32'hFFFF_FFFF);  rd(A_IRQ, v);  check("R2 irq bits", v, IEN);
        wr(A_CNT, 32'hF000_0005);  rd(A_CNT, v);  check("R10 count load", v, 5);
        step(10); rd(A_CNT, v); check("R10 idle hold", v, 5);
        wr(A_CNT, 32'h0); rd(A_CNT, v); check("R10 zero load", v, 0);

        // R3/R5/R9 exact edge of the first match, periodic, D=3, N=4
        arm(4, 3, 1'b1);
        step(14); check("R5 irq before match", {31'b0, irq_o}, 0);
        step(1);  check("R5 irq at match", {31'b0, irq_o}, 1);
        rd(A_CNT, v); check("R6 wrap to zero", v, 0);
        // R8 writing 0 to flag bit keeps it
        wr(A_IRQ, IEN); check("R8 write zero keeps", {31'b0, irq_o}, 1);
        // R9 mask
        wr(A_IRQ, 32'h0); check("R9 masked", {31'b0, irq_o}, 0);
        wr(A_IRQ, IEN);   check("R9 unmasked", {31'b0, irq_o}, 1);
        wr(A_IRQ, IEN | FLG); check("R8 clear", {31'b0, irq_o}, 0);

        // R8 set wins over a clear in the same cycle: next match at E+30
        // the writes above used 4 edges after the match edge E+15
        step(30 - 15 - 4 - 1);
        wr(A_IRQ, IEN | FLG);
        check("R8 set beats clear", {31'b0, irq_o}, 1);
        rd(A_CNT, v); check("R6 second wrap", v, 0);

        // R10 stop by writing zero to control
        step(7); wr(A_CTRL, 32'h0); rd(A_CNT, v);
        step(12);
        begin
            logic [31:0] w;
            rd(A_CNT, w); check("R10 stopped holds", w, v);
        end

        // R7 single-shot, D=1 treated as 2 (R4), N=3
        arm(3, 1, 1'b0);
        step(8); rd(A_CTRL, v); check("R7 run cleared", v & RUN, 0);
        check("R7 irq", {31'b0, irq_o}, 1);
        step(20); rd(A_CNT, v); check("R7 count holds at term", v, 3);

        // R3/R4/R6/R7/R11 random runs
        for (int i = 0; i < 24; i++) begin
            int d = $urandom_range(0, 5);
            int n = $urandom_range(1, 30);
            bit per = 1'($urandom_range(0, 1));
            int m = $urandom_range(0, 3 * (n + 1) * eff(d));
            arm(n, d, per);
            step(m);
            rd(A_CNT, v);
            check(per ? "R11 R3 R4 R6 live count" : "R11 R3 R4 R7 live count",
                  v, 32'(exp_count(m, d, n, per)));
            check("R5 R9 irq", {31'b0, irq_o}, {31'b0, m >= (n + 1) * eff(d)});
            if (!per) begin
                rd(A_CTRL, v);
                check("R7 run bit", v & RUN, (m < (n + 1) * eff(d)) ? RUN : 0);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule